// File: doc/BRIEF.md
# Next-Free-Address Finder

The block looks at a vector of per-entry validity flags, one bit per storage location, where a set bit marks a location as free. From this vector it finds the free location with the best priority, which is the one a later write-to-next-free operation would use. Location 0 has the highest priority, and priority falls as the index rises. The storage itself sits outside the block. The flag vector comes in as a plain input. The search runs in two registered stages: per-group encoders, then a merge over the groups. The answer is always ready, so a read request is served from a register in a single cycle.

Several copies can be chained in a vertical cascade. Each device takes an active-low "upstream full" input and drives an active-low "full" output to the next device. On a read request, only the first device in the chain that still has a free entry answers. The answer is a 32-bit word. The location index sits in the low bits, the device's 4-bit page number sits in bits 19:16, and every other bit is zero.

Top module: `nfa_finder`

## Requirements
- R1: A set bit in `valid_vec` means the entry is free. The reported index is the lowest-numbered set bit and sits in `nfa_word[IDX_W-1:0]`, where IDX_W = log2(DEPTH).
- R2: In a response word, bits 19:16 hold `page_id`, bits 31:20 are zero, and bits 15:IDX_W are zero.
- R3: `full_out_n` is low only when `full_in_n` is low and no bit of `valid_vec` is set. When `full_in_n` is high, `full_out_n` is high.
- R4: A device answers a read only when `full_in_n` is low and it has at least one free entry. Otherwise `nfa_oe` stays low and `nfa_word` stays zero.
- R5: A read request sampled on a rising edge produces `nfa_oe` high and the word in the following cycle, for that one cycle only. When no request is sampled, `nfa_oe` is low and `nfa_word` is zero.
- R6: A change in `valid_vec` reaches `full_out_n` and the read result two rising edges after it is sampled. A read sampled on the same edge as the change returns the result for the previous vector.
- R7: While synchronous reset is held and in the first cycle after it, `nfa_oe` is low and `nfa_word` is zero.
- R8: In a cascade of two devices, the upstream device answers while it has a free entry. The downstream device answers only once the upstream one is full. At most one device asserts `nfa_oe` in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_vec | input | DEPTH | Per-entry free flags, 1 = free |
| page_id | input | 4 | Page number of this device |
| full_in_n | input | 1 | Active low: every upstream device is full (tie low on the first device) |
| rd_nfa | input | 1 | Read-next-free request |
| full_out_n | output | 1 | Active low: this device and all devices upstream are full |
| nfa_oe | output | 1 | Response valid / drive enable |
| nfa_word | output | 32 | Response word: index, page number, zeros |

## Verification
Two events can fall in the same cycle: a read request, and a change of the validity vector that the read would see. The bench changes the vector at the same clock edge on which it raises the request. It expects the answer for the old vector, and then expects the answer for the new one two cycles later. A second pairing is the cascade handoff, where the upstream device turns full just as the downstream device is asked to answer. Both devices receive every read, and the bench checks that exactly the expected device responds, with the right page number.

// File: rtl/nfa_pkg.sv
package nfa_pkg;
  localparam int WORD_W   = 32;
  localparam int PAGE_W   = 4;
  localparam int PAGE_LSB = 16;
  localparam int IDX_MAXW = 16;

  // Assemble a response word: index low, page at fixed offset, rest zero.
  function automatic logic [WORD_W-1:0] pack_word(
    input logic [IDX_MAXW-1:0] idx,
    input logic [PAGE_W-1:0]   page
  );
    logic [WORD_W-1:0] w;
    w = '0;
    w[IDX_MAXW-1:0] = idx;
    w[PAGE_LSB +: PAGE_W] = page;
    return w;
  endfunction
endpackage

// File: rtl/nfa_leaf_enc.sv
// Combinational priority encoder: lowest set bit wins.
module nfa_leaf_enc #(
  parameter int WIDTH = 16,
  localparam int IW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] bits,
  output logic             any,
  output logic [IW-1:0]    idx
);
  always_comb begin
    idx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (bits[i]) idx = IW'(i);
    end
    any = |bits;
  end
endmodule

// File: rtl/nfa_scan_stage.sv
// Stage 1: one leaf encoder per group, results registered.
module nfa_scan_stage #(
  parameter int DEPTH = 4096,
  parameter int GROUP = 16,
  localparam int NG   = DEPTH / GROUP,
  localparam int LW   = $clog2(GROUP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEPTH-1:0] vec,
  output logic [NG-1:0]    grp_any,
  output logic [NG*LW-1:0] grp_idx
);
  logic [NG-1:0]    leaf_any;
  logic [NG*LW-1:0] leaf_idx;

  for (genvar g = 0; g < NG; g++) begin : g_leaf
    nfa_leaf_enc #(.WIDTH(GROUP)) u_leaf (
      .bits (vec[g*GROUP +: GROUP]),
      .any  (leaf_any[g]),
      .idx  (leaf_idx[g*LW +: LW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_any <= '0;
      grp_idx <= '0;
    end else begin
      grp_any <= leaf_any;
      grp_idx <= leaf_idx;
    end
  end
endmodule

// File: rtl/nfa_merge_stage.sv
// Stage 2: pick the first group holding a free entry, join its local index.
module nfa_merge_stage #(
  parameter int NG    = 256,
  parameter int LW    = 4,
  localparam int GIW  = $clog2(NG),
  localparam int IDX_W = GIW + LW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NG-1:0]    grp_any,
  input  logic [NG*LW-1:0] grp_idx,
  output logic             found_q,
  output logic [IDX_W-1:0] idx_q
);
  logic           any_g;
  logic [GIW-1:0] sel_g;
  logic [LW-1:0]  local_idx;

  nfa_leaf_enc #(.WIDTH(NG)) u_grp_enc (
    .bits (grp_any),
    .any  (any_g),
    .idx  (sel_g)
  );

  always_comb begin
    local_idx = grp_idx[int'(sel_g)*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      found_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      found_q <= any_g;
      idx_q   <= {sel_g, local_idx};
    end
  end
endmodule

// File: rtl/nfa_resp.sv
// Response register: drives the word for one cycle per granted read.
module nfa_resp
  import nfa_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd,
  input  logic               sel,
  input  logic [IDX_W-1:0]   idx,
  input  logic [PAGE_W-1:0]  page,
  output logic               oe,
  output logic [WORD_W-1:0]  word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      oe   <= 1'b0;
      word <= '0;
    end else if (rd && sel) begin
      oe   <= 1'b1;
      word <= pack_word(IDX_MAXW'(idx), page);
    end else begin
      oe   <= 1'b0;
      word <= '0;
    end
  end
endmodule

// File: rtl/nfa_finder.sv
module nfa_finder
  import nfa_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int GROUP = 16,
  localparam int NG    = DEPTH / GROUP,
  localparam int LW    = $clog2(GROUP),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [DEPTH-1:0]       valid_vec,
  input  logic [3:0]             page_id,
  input  logic                   full_in_n,
  input  logic                   rd_nfa,
  output logic                   full_out_n,
  output logic                   nfa_oe,
  output logic [31:0]            nfa_word
);
  logic [NG-1:0]    grp_any;
  logic [NG*LW-1:0] grp_idx;
  logic             found_q;
  logic [IDX_W-1:0] idx_q;
  logic             sel;

  nfa_scan_stage #(.DEPTH(DEPTH), .GROUP(GROUP)) u_scan (
    .clk     (clk),
    .rst     (rst),
    .vec     (valid_vec),
    .grp_any (grp_any),
    .grp_idx (grp_idx)
  );

  nfa_merge_stage #(.NG(NG), .LW(LW)) u_merge (
    .clk     (clk),
    .rst     (rst),
    .grp_any (grp_any),
    .grp_idx (grp_idx),
    .found_q (found_q),
    .idx_q   (idx_q)
  );

  // Chain is full here only if upstream is full and no local entry is free.
  assign full_out_n = found_q | full_in_n;
  assign sel        = found_q & ~full_in_n;

  nfa_resp #(.IDX_W(IDX_W)) u_resp (
    .clk  (clk),
    .rst  (rst),
    .rd   (rd_nfa),
    .sel  (sel),
    .idx  (idx_q),
    .page (page_id),
    .oe   (nfa_oe),
    .word (nfa_word)
  );
endmodule

// File: rtl/nfa_finder_chk.sv
module nfa_finder_chk #(
  parameter int IDX_W = 12
) (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  page_id,
  input logic        full_in_n,
  input logic        rd_nfa,
  input logic        full_out_n,
  input logic        nfa_oe,
  input logic [31:0] nfa_word
);
  // R5
  oe_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    nfa_oe |-> $past(rd_nfa));
  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !nfa_oe |-> (nfa_word == 32'h0));
  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    nfa_word[31:20] == 12'h0);
  // R2
  page_field_chk: assert property (@(posedge clk) disable iff (rst)
    nfa_oe |-> (nfa_word[19:16] == $past(page_id)));
  // R2
  mid_zero_chk: assert property (@(posedge clk) disable iff (rst)
    nfa_word[15:0] >> IDX_W == 16'h0);
  // R3
  full_pass_chk: assert property (@(posedge clk) disable iff (rst)
    full_in_n |-> full_out_n);
  // R4
  grant_chk: assert property (@(posedge clk) disable iff (rst)
    nfa_oe |-> ($past(full_out_n) && !$past(full_in_n)));
  // R7
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!nfa_oe && nfa_word == 32'h0));
endmodule

bind nfa_finder nfa_finder_chk #(.IDX_W(IDX_W)) u_nfa_chk (
  .clk        (clk),
  .rst        (rst),
  .page_id    (page_id),
  .full_in_n  (full_in_n),
  .rd_nfa     (rd_nfa),
  .full_out_n (full_out_n),
  .nfa_oe     (nfa_oe),
  .nfa_word   (nfa_word)
);

// File: tb/test_nfa_finder.sv
`timescale 1ns/1ps
module test_nfa_finder;
  localparam int D  = 64;
  localparam int G  = 8;
  localparam int IW = $clog2(D);
  localparam logic [3:0] PG_A = 4'h3;
  localparam logic [3:0] PG_B = 4'hA;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd  = 1'b0;
  logic [D-1:0] vec_a = '0;
  logic [D-1:0] vec_b = '0;
  logic fo_a, fo_b, oe_a, oe_b;
  logic [31:0] w_a, w_b;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  nfa_finder #(.DEPTH(D), .GROUP(G)) i_nfa_finder (
    .clk(clk), .rst(rst), .valid_vec(vec_a), .page_id(PG_A),
    .full_in_n(1'b0), .rd_nfa(rd), .full_out_n(fo_a),
    .nfa_oe(oe_a), .nfa_word(w_a));

  nfa_finder #(.DEPTH(D), .GROUP(G)) i_nfa_finder_b (
    .clk(clk), .rst(rst), .valid_vec(vec_b), .page_id(PG_B),
    .full_in_n(fo_a), .rd_nfa(rd), .full_out_n(fo_b),
    .nfa_oe(oe_b), .nfa_word(w_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [D-1:0] v, input logic [3:0] pg);
    for (int i = 0; i < D; i++)
      if (v[i]) return (32'(pg) << 16) | 32'(i);
    return 32'h0;
  endfunction

  // Read both devices and compare against values derived from the vectors.
  task automatic read_chk(input string req, input logic [D-1:0] va, input logic [D-1:0] vb);
    logic sa, sb;
    sa = (va != '0);
    sb = (va == '0) && (vb != '0);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk({req, " R4 R8 oe_a"}, 32'(oe_a), 32'(sa));
    chk({req, " R4 R8 oe_b"}, 32'(oe_b), 32'(sb));
    chk({req, " R1 R2 word_a"}, w_a, sa ? exp_word(va, PG_A) : 32'h0);
    chk({req, " R1 R2 word_b"}, w_b, sb ? exp_word(vb, PG_B) : 32'h0);
    @(negedge clk);
    chk({req, " R5 oe pulse"}, 32'({oe_a, oe_b}), 32'h0);
    chk({req, " R5 idle word"}, w_a | w_b, 32'h0);
  endtask

  task automatic apply(input string req, input logic [D-1:0] va, input logic [D-1:0] vb);
    vec_a = va;
    vec_b = vb;
    repeat (2) @(negedge clk);
    chk({req, " R3 R6 fo_a"}, 32'(fo_a), 32'(va != '0));
    chk({req, " R3 fo_b"}, 32'(fo_b), 32'((va != '0) || (vb != '0)));
    read_chk(req, va, vb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [D-1:0] p1, p2;
    repeat (3) @(negedge clk);
    // R7: quiet while in reset
    chk("R7 oe in reset", 32'({oe_a, oe_b}), 32'h0);
    chk("R7 word in reset", w_a | w_b, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 oe after reset", 32'({oe_a, oe_b}), 32'h0);
    // R5: no request, no response
    vec_a = '1;
    repeat (4) @(negedge clk);
    chk("R5 no read oe", 32'(oe_a), 32'h0);
    chk("R5 no read word", w_a, 32'h0);

    apply("all free", '1, '1);
    apply("both full", '0, '0);
    // single free entry at each position of device A
    for (int i = 0; i < D; i++) apply("single A", D'(1) << i, '1);
    // cascade handoff: A full, B single entry at each end and patterns
    apply("handoff B low", '0, D'(1));
    apply("handoff B high", '0, D'(1) << (D - 1));
    apply("A full B full", '0, '0);
    apply("A one B full", D'(1) << (D - 1), '0);
    for (int k = 0; k < 40; k++) begin
      p1 = (64'h9E3779B97F4A7C15 * 64'(k + 1)) & ({D{1'b1}} << (k % D));
      p2 = (64'hC2B2AE3D27D4EB4F * 64'(k + 3)) & ({D{1'b1}} << ((k * 7) % D));
      apply("pattern A", p1, p2);
      apply("pattern B", '0, p2);
    end

    // R6: read sampled on the same edge as a vector change sees the old vector
    p1 = D'(1) << 5;
    p2 = D'(1) << 40;
    apply("R6 setup", p1, '0);
    vec_a = p2;
    read_chk("R6 same edge", p1, '0);
    read_chk("R6 new vector", p2, '0);
    // R6 handoff in the same cycle: A turns full at the read edge
    vec_a = '0;
    vec_b = D'(1) << 9;
    read_chk("R6 R8 handoff edge", p2, vec_b);
    read_chk("R6 R8 handoff done", '0, vec_b);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule